// File: doc/BRIEF.md
# Bidirectional Parallel-Lane Shift Register Array

This block is a bank of serial shift registers, called lanes, that share one clock. Each lane fills its own fixed slice of a wide parallel word, so the whole word loads as many times faster as there are lanes. With the default of six 16-bit lanes, a 30 MHz clock gives an aggregate load rate of 180 Mbit/s into a 96-bit word. The full contents of every register bit are presented at all times to a downstream holding latch.

Each lane has two serial ports, A and B. Each port is modelled as a separate input, output and output-enable. A single direction input chooses the roles of the ports. When it is low, A is the serial input and data moves toward the high-numbered end of the lane. When it is high, B is the serial input and data moves toward the low-numbered end. The opposite port always presents the stage that would be shifted out next, so it can feed the matching port of a following device in a cascade.

A synchronous, active-high reset clears all stages. It also holds both serial outputs low for as long as it is asserted.

Top module: `bidir_lane_array`

## Requirements
- R1: While `rst` is high, `a_out` and `b_out` are all zero. A rising clock edge with `rst` high leaves every bit of `word` at 0.
- R2: With `rst` low and `dir` = 0 at a rising edge, each lane n (0-based) loads `a_in[n]` into `word[16n]` and moves each bit `word[16n+k]` to `word[16n+k+1]`. `b_in` has no effect.
- R3: With `rst` low and `dir` = 1 at a rising edge, each lane n loads `b_in[n]` into `word[16n+15]` and moves each bit `word[16n+k+1]` to `word[16n+k]`. `a_in` has no effect.
- R4: `a_oe[n]` equals `dir` and `b_oe[n]` equals the inverse of `dir` for every lane, at all times.
- R5: With `rst` low, the active serial output shows the last stage in the current direction. For `dir` = 0, `b_out[n]` = `word[16n+15]`. For `dir` = 1, `a_out[n]` = `word[16n]`. The port that is not driving reads 0.
- R6: Lane n owns exactly bits 16n to 16n+15 of `word`. Bit 0 of `word` is the first channel. A serial bit on one lane never reaches another lane's slice.
- R7: Changing `dir` between edges takes effect at the next edge and leaves the stored bits unchanged until that edge shifts them in the new direction.
- R8: Reset wins over shifting. An edge with `rst` high clears `word` whatever `dir`, `a_in` and `b_in` are.
- R9: A bit presented on the serial input appears on the opposite serial output after exactly 16 rising edges, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dir | input | 1 | 0: A feeds in and shifts upward; 1: B feeds in and shifts downward |
| a_in | input | 6 | Port A serial input, one bit per lane |
| b_in | input | 6 | Port B serial input, one bit per lane |
| a_out | output | 6 | Port A serial output, one bit per lane |
| a_oe | output | 6 | Port A output enable, one bit per lane |
| b_out | output | 6 | Port B serial output, one bit per lane |
| b_oe | output | 6 | Port B output enable, one bit per lane |
| word | output | 96 | Parallel contents of all lanes; lane n in bits 16n..16n+15 |

## Verification
The properties assume that `dir`, `rst` and both serial inputs are stable around each rising edge. Under that assumption, the value sampled at an edge is the value that shifts in.

The shift properties also assume that the cycle before the checked edge was a normal cycle, not a reset cycle. For that reason they are disabled while `rst` is high.

The stimulus changes every input only on the falling clock edge, so the inputs are settled half a period before the design samples them. The vector table deliberately changes `dir` between consecutive edges and puts arbitrary values on the unused serial input, so both direction switches and ignored inputs occur under these conditions.

// File: rtl/bidir_lane_pkg.sv
package bidir_lane_pkg;

   typedef enum logic {
      SHIFT_UP   = 1'b0,
      SHIFT_DOWN = 1'b1
   } shift_dir_e;

endpackage

// File: rtl/lane_shifter.sv
module lane_shifter
   import bidir_lane_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  shift_dir_e       dir,
   input  logic             up_in,
   input  logic             down_in,
   output logic [WIDTH-1:0] stages
);

   logic [WIDTH-1:0] nxt;

   always_comb begin
      if (dir == SHIFT_UP) begin
         nxt = {stages[WIDTH-2:0], up_in};
      end else begin
         nxt = {down_in, stages[WIDTH-1:1]};
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         stages <= '0;
      end else begin
         stages <= nxt;
      end
   end

endmodule

// File: rtl/lane_port_steer.sv
module lane_port_steer
   import bidir_lane_pkg::*;
(
   input  logic       rst,
   input  shift_dir_e dir,
   input  logic       low_stage,
   input  logic       high_stage,
   output logic       a_out,
   output logic       a_oe,
   output logic       b_out,
   output logic       b_oe
);

   logic down;

   assign down  = (dir == SHIFT_DOWN);
   assign a_oe  = down;
   assign b_oe  = ~down;
   assign a_out = down & ~rst & low_stage;
   assign b_out = ~down & ~rst & high_stage;

endmodule

// File: rtl/bidir_lane_array.sv
module bidir_lane_array
   import bidir_lane_pkg::*;
#(
   parameter int LANES = 6,
   parameter int WIDTH = 16,
   localparam int TOTAL = LANES * WIDTH
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             dir,
   input  logic [LANES-1:0] a_in,
   input  logic [LANES-1:0] b_in,
   output logic [LANES-1:0] a_out,
   output logic [LANES-1:0] a_oe,
   output logic [LANES-1:0] b_out,
   output logic [LANES-1:0] b_oe,
   output logic [TOTAL-1:0] word
);

   if (LANES < 1) begin : g_bad_lanes
      $error("bidir_lane_array: LANES must be at least 1");
   end
   if (WIDTH < 2) begin : g_bad_width
      $error("bidir_lane_array: WIDTH must be at least 2");
   end

   shift_dir_e dir_e;
   assign dir_e = shift_dir_e'(dir);

   for (genvar n = 0; n < LANES; n++) begin : g_lane
      localparam int BASE = n * WIDTH;
      logic [WIDTH-1:0] stages;

      lane_shifter #(.WIDTH(WIDTH)) u_shift (
         .clk     (clk),
         .rst     (rst),
         .dir     (dir_e),
         .up_in   (a_in[n]),
         .down_in (b_in[n]),
         .stages  (stages)
      );

      lane_port_steer u_steer (
         .rst        (rst),
         .dir        (dir_e),
         .low_stage  (stages[0]),
         .high_stage (stages[WIDTH-1]),
         .a_out      (a_out[n]),
         .a_oe       (a_oe[n]),
         .b_out      (b_out[n]),
         .b_oe       (b_oe[n])
      );

      assign word[BASE +: WIDTH] = stages;
   end

endmodule

// File: rtl/bidir_lane_array_chk.sv
module bidir_lane_array_chk #(
   parameter int LANES = 6,
   parameter int WIDTH = 16,
   localparam int TOTAL = LANES * WIDTH
) (
   input logic             clk,
   input logic             rst,
   input logic             dir,
   input logic [LANES-1:0] a_in,
   input logic [LANES-1:0] b_in,
   input logic [LANES-1:0] a_out,
   input logic [LANES-1:0] a_oe,
   input logic [LANES-1:0] b_out,
   input logic [LANES-1:0] b_oe,
   input logic [TOTAL-1:0] word
);

   // R1 R8
   reset_clear_chk: assert property (@(posedge clk) rst |=> word == '0);

   // R1
   reset_quiet_chk: assert property (@(posedge clk) rst |-> (a_out == '0 && b_out == '0));

   // R4
   oe_dir_chk: assert property (@(posedge clk)
      (a_oe == {LANES{dir}}) && (b_oe == {LANES{~dir}}));

   for (genvar n = 0; n < LANES; n++) begin : g_lchk
      localparam int LO = n * WIDTH;
      localparam int HI = LO + WIDTH - 1;

      // R2 R6
      shift_up_chk: assert property (@(posedge clk) disable iff (rst)
         !dir |=> (word[LO] == $past(a_in[n]))
               && (word[LO+1 +: WIDTH-1] == $past(word[LO +: WIDTH-1])));

      // R3 R6
      shift_down_chk: assert property (@(posedge clk) disable iff (rst)
         dir |=> (word[HI] == $past(b_in[n]))
              && (word[LO +: WIDTH-1] == $past(word[LO+1 +: WIDTH-1])));

      // R5
      tail_up_chk: assert property (@(posedge clk) disable iff (rst)
         !dir |-> (b_out[n] == word[HI]) && !a_out[n]);

      // R5
      tail_down_chk: assert property (@(posedge clk) disable iff (rst)
         dir |-> (a_out[n] == word[LO]) && !b_out[n]);
   end

endmodule

bind bidir_lane_array bidir_lane_array_chk #(
   .LANES(LANES),
   .WIDTH(WIDTH)
) u_chk (
   .clk   (clk),
   .rst   (rst),
   .dir   (dir),
   .a_in  (a_in),
   .b_in  (b_in),
   .a_out (a_out),
   .a_oe  (a_oe),
   .b_out (b_out),
   .b_oe  (b_oe),
   .word  (word)
);

// File: tb/bidir_lane_array_test.sv
module bidir_lane_array_test;

   localparam int L = 6;
   localparam int W = 16;
   localparam int N = L * W;
   localparam int NV = 20;

   // Each vector is {dir, a_in[5:0], b_in[5:0]}.
   localparam logic [12:0] VEC [NV] = '{
      13'h0A5C, 13'h0123, 13'h0FFF, 13'h003F, 13'h0FC0,
      13'h0555, 13'h0AAA, 13'h1234, 13'h1FFF, 13'h1E1E,
      13'h1001, 13'h1842, 13'h0777, 13'h1999, 13'h0000,
      13'h1F0F, 13'h0C3C, 13'h0E07, 13'h1B6D, 13'h0246
   };

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic         rst = 1'b1;
   logic         dir = 1'b0;
   logic [L-1:0] a_in = '0;
   logic [L-1:0] b_in = '0;
   logic [L-1:0] a_out, a_oe, b_out, b_oe;
   logic [N-1:0] word;

   logic [N-1:0] m;
   int checks = 0;
   int fails = 0;

   bidir_lane_array uut (
      .clk   (clk),
      .rst   (rst),
      .dir   (dir),
      .a_in  (a_in),
      .b_in  (b_in),
      .a_out (a_out),
      .a_oe  (a_oe),
      .b_out (b_out),
      .b_oe  (b_oe),
      .word  (word)
   );

   task automatic check(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic r, input logic d, input logic [L-1:0] a, input logic [L-1:0] b);
      rst = r; dir = d; a_in = a; b_in = b;
   endtask

   // One rising edge; the reference model follows the requirements.
   task automatic tick();
      @(posedge clk);
      for (int n = 0; n < L; n++) begin
         if (rst) m[n*W +: W] = '0;
         else if (!dir) m[n*W +: W] = {m[n*W +: W-1], a_in[n]};
         else m[n*W +: W] = {b_in[n], m[n*W+1 +: W-1]};
      end
      @(negedge clk);
   endtask

   task automatic check_all(input string req);
      logic [L-1:0] ea, eb;
      for (int n = 0; n < L; n++) begin
         ea[n] = (!rst && dir) ? m[n*W] : 1'b0;
         eb[n] = (!rst && !dir) ? m[n*W+W-1] : 1'b0;
      end
      check(word === m, {req, " word"}, word, m);
      check({a_out, b_out} === {ea, eb}, "R5 R1 serial outs", N'({a_out, b_out}), N'({ea, eb}));
      check({a_oe, b_oe} === {{L{dir}}, {L{~dir}}}, "R4 oe", N'({a_oe, b_oe}), N'({{L{dir}}, {L{~dir}}}));
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(20 * 100000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      m = '0;
      @(negedge clk);
      drive(1'b1, 1'b0, '0, '0);
      tick();
      tick();
      check_all("R1 reset state");

      // R2 R3 R7: table walk, dir changes between edges, unused input ignored
      drive(1'b0, 1'b0, '0, '0);
      for (int i = 0; i < NV; i++) begin
         drive(1'b0, VEC[i][12], VEC[i][11:6], VEC[i][5:0]);
         tick();
         check_all(VEC[i][12] ? "R3 R7" : "R2 R7");
      end

      // R1: serial outputs low while reset is high, before the clearing edge
      drive(1'b0, 1'b0, '1, '0);
      for (int i = 0; i < W; i++) tick();
      check(b_out === '1, "R5 tail", N'(b_out), N'({L{1'b1}}));
      drive(1'b1, 1'b0, '1, '0);
      #1;
      check({a_out, b_out} === '0, "R1 outs during reset", N'({a_out, b_out}), '0);

      // R8: reset wins over active shifting inputs
      drive(1'b1, 1'b1, '1, '1);
      tick();
      check(word === '0, "R8 reset priority", word, '0);
      check_all("R8");

      // R6: lane slices
      drive(1'b0, 1'b0, 6'b000001, '1);
      tick();
      check(word === N'(1), "R6 lane0 low bit", word, N'(1));
      drive(1'b1, 1'b0, '0, '0);
      tick();
      drive(1'b0, 1'b0, 6'b100000, '0);
      tick();
      check(word === (N'(1) << 80), "R6 lane5 low bit", word, N'(1) << 80);
      drive(1'b1, 1'b0, '0, '0);
      tick();
      drive(1'b0, 1'b1, '1, 6'b000001);
      tick();
      check(word === (N'(1) << 15), "R6 lane0 high bit", word, N'(1) << 15);
      check_all("R6");

      // R9: cascade latency of 16 edges, upward then downward
      drive(1'b1, 1'b0, '0, '0);
      tick();
      drive(1'b0, 1'b0, '1, '0);
      tick();
      drive(1'b0, 1'b0, '0, '0);
      for (int i = 1; i < W; i++) begin
         check(b_out === '0, "R9 early up", N'(b_out), '0);
         tick();
      end
      check(b_out === '1, "R9 arrival up", N'(b_out), N'({L{1'b1}}));
      drive(1'b1, 1'b1, '0, '0);
      tick();
      drive(1'b0, 1'b1, '0, '1);
      tick();
      drive(1'b0, 1'b1, '0, '0);
      for (int i = 1; i < W; i++) begin
         check(a_out === '0, "R9 early down", N'(a_out), '0);
         tick();
      end
      check(a_out === '1, "R9 arrival down", N'(a_out), N'({L{1'b1}}));
      check_all("R9 R3");

      finish_run();
   end

endmodule